// File: doc/BRIEF.md
# Control-Packet Memory Access Endpoint

This block is a leaf node on a byte-wide control network. Requests arrive as AXI4-Stream packets, one byte per beat, with a routing header in front of a type byte. The endpoint serves reads and writes against its own 256-byte RAM. It also answers an identify request with a fixed descriptor. Each accepted request produces exactly one reply packet on the output stream.

The routing header is a forward-path list followed by a return-path list. Each list is a length byte followed by that many bytes. The reply exchanges the two lists, so the route a request arrived on becomes the return route of its answer. Both list lengths are limited by the parameter `MAX_PATH`.

Requests that are unknown, truncated or badly routed are consumed up to `tlast` and produce no reply. While a reply is being sent, the input stream is held off.

Top module: `ctl_mem_endpoint`

## Requirements
- R1: After reset the output stream is idle (`mValid` low) and the input stream is ready (`sReady` high).
- R2: Type byte 0xFE (identify) is answered with type 0xFF followed by a 32-byte descriptor. The descriptor bytes are 0x01, 0x08, 0x00 and 0x01 at positions 0 to 3. Byte i for i from 4 to 31 is 0x40+i.
- R3: Type byte 0x10 (read) carries an address byte and then a 16-bit byte count, low byte first. It is answered with type 0x11, then the address, count low and count high, then `count` bytes read from RAM starting at the address.
- R4: Type byte 0x12 (write) carries the address, the 16-bit count (low byte first) and then data bytes. The first `count` data bytes are stored at successive addresses; any further bytes are ignored. The reply is type 0x13 followed by the address, count low and count high, with no data.
- R5: A reply begins with the request's return-path length and return-path bytes, followed by the request's forward-path length and forward-path bytes, and then the response type. Two empty lists produce two zero length bytes.
- R6: During a burst, the RAM address advances by one per data byte and wraps from 0xFF to 0x00.
- R7: A packet whose type byte is anything other than 0x10, 0x12 or 0xFE is consumed and produces no reply.
- R8: A packet that ends before its type byte, or a read or write that ends before its count high byte, produces no reply.
- R9: A packet whose forward-path or return-path length exceeds `MAX_PATH` (default 4) produces no reply.
- R10: While `mValid` is high and `mReady` is low, `mData` and `mLast` hold their values. `mLast` is high only on the final byte of a reply.
- R11: `sReady` is low for as long as a reply is pending. It returns high on the cycle after the beat that carries `mLast`.
- R12: A read with count 0 is answered by a reply that ends at the count high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sData | input | 8 | Request byte |
| sValid | input | 1 | Request byte valid |
| sLast | input | 1 | Final byte of the request packet |
| sReady | output | 1 | Endpoint accepts a request byte |
| mData | output | 8 | Reply byte |
| mValid | output | 1 | Reply byte valid |
| mLast | output | 1 | Final byte of the reply packet |
| mReady | input | 1 | Downstream accepts a reply byte |

## Verification
The assertions assume the upstream source never relies on a byte being taken while `sReady` is low. They also assume `mReady` may drop at any cycle, so hold behaviour under stall must come from the endpoint alone. The stimulus changes input signals only between clock edges and waits for `sReady` before presenting each byte. It drives `mReady` from a pseudo-random pattern in the stalled phases. Reads only cover RAM locations the bench has already written, because RAM contents are undefined after reset.

// File: rtl/cpkt_pkg.sv
package cpkt_pkg;
  localparam logic [7:0] TYP_IDENT = 8'hFE;
  localparam logic [7:0] TYP_READ  = 8'h10;
  localparam logic [7:0] TYP_WRITE = 8'h12;
  localparam int DESC_LEN = 32;
  localparam int ADDR_W   = 8;
  localparam int RAM_BYTES = 1 << ADDR_W;

  typedef enum logic [2:0] {
    OS_CONST, OS_FWD, OS_RET, OS_ADDR, OS_RAM
  } outSel_e;

  typedef struct packed {
    logic    fwdWe;
    logic    retWe;
    logic    addrLd;
    logic    ramWe;
    logic    addrAdv;
    outSel_e outSel;
  } strobe_t;

  function automatic logic [7:0] descByte(input logic [7:0] i);
    logic [15:0] sz;
    sz = 16'(RAM_BYTES);
    case (i)
      8'd0: descByte = 8'h01;
      8'd1: descByte = 8'(ADDR_W);
      8'd2: descByte = sz[7:0];
      8'd3: descByte = sz[15:8];
      default: descByte = 8'h40 + i;
    endcase
  endfunction
endpackage

// File: rtl/cpkt_ctl.sv
module cpkt_ctl
  import cpkt_pkg::*;
#(
  parameter int MAX_PATH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sData,
  input  logic       sValid,
  input  logic       sLast,
  output logic       sReady,
  input  logic       mReady,
  output logic       mValid,
  output logic       mLast,
  output logic [7:0] constByte,
  output logic [7:0] slotIdx,
  output strobe_t    strobe
);
  typedef enum logic [4:0] {
    S_FLEN, S_FWD, S_RLEN, S_RET, S_TYPE, S_ADDR, S_CLO, S_CHI, S_BODY, S_DROP,
    R_LEN1, R_RET, R_LEN2, R_FWD, R_TYPE, R_ADDR, R_CLO, R_CHI, R_DATA, R_DESC
  } state_e;

  state_e state;
  logic [7:0]  fLen, rLen, typ, idx;
  logic [15:0] cnt, dCnt;
  logic inReply, inBeat, outBeat, bodyWr;

  assign inReply = (state >= R_LEN1);
  assign sReady  = !inReply;
  assign mValid  = inReply;
  assign inBeat  = sValid && sReady;
  assign outBeat = mValid && mReady;
  assign slotIdx = idx;
  assign bodyWr  = (typ == TYP_WRITE) && (dCnt < cnt);

  always_comb begin
    strobe    = '0;
    constByte = 8'h00;
    mLast     = 1'b0;
    case (state)
      S_FWD:  strobe.fwdWe  = inBeat;
      S_RET:  strobe.retWe  = inBeat;
      S_ADDR: strobe.addrLd = inBeat;
      S_BODY: begin
        strobe.ramWe   = inBeat && bodyWr;
        strobe.addrAdv = inBeat && bodyWr;
      end
      R_LEN1: constByte = rLen;
      R_RET:  strobe.outSel = OS_RET;
      R_LEN2: constByte = fLen;
      R_FWD:  strobe.outSel = OS_FWD;
      R_TYPE: constByte = typ + 8'd1;
      R_ADDR: strobe.outSel = OS_ADDR;
      R_CLO:  constByte = cnt[7:0];
      R_CHI: begin
        constByte = cnt[15:8];
        mLast = (typ != TYP_READ) || (cnt == 16'd0);
      end
      R_DATA: begin
        strobe.outSel  = OS_RAM;
        strobe.addrAdv = outBeat;
        mLast = (dCnt == cnt - 16'd1);
      end
      R_DESC: begin
        constByte = descByte(idx);
        mLast = (idx == 8'(DESC_LEN - 1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FLEN;
      fLen <= '0; rLen <= '0; typ <= '0; idx <= '0;
      cnt <= '0; dCnt <= '0;
    end else begin
      case (state)
        S_FLEN: if (inBeat) begin
          fLen <= sData; idx <= '0;
          if (sLast) state <= S_FLEN;
          else if (sData > 8'(MAX_PATH)) state <= S_DROP;
          else if (sData == 8'd0) state <= S_RLEN;
          else state <= S_FWD;
        end
        S_FWD: if (inBeat) begin
          if (sLast) state <= S_FLEN;
          else if (idx == fLen - 8'd1) state <= S_RLEN;
          else idx <= idx + 8'd1;
        end
        S_RLEN: if (inBeat) begin
          rLen <= sData; idx <= '0;
          if (sLast) state <= S_FLEN;
          else if (sData > 8'(MAX_PATH)) state <= S_DROP;
          else if (sData == 8'd0) state <= S_TYPE;
          else state <= S_RET;
        end
        S_RET: if (inBeat) begin
          if (sLast) state <= S_FLEN;
          else if (idx == rLen - 8'd1) state <= S_TYPE;
          else idx <= idx + 8'd1;
        end
        S_TYPE: if (inBeat) begin
          typ <= sData;
          if (sLast) state <= (sData == TYP_IDENT) ? R_LEN1 : S_FLEN;
          else if (sData == TYP_IDENT) state <= S_BODY;
          else if (sData == TYP_READ || sData == TYP_WRITE) state <= S_ADDR;
          else state <= S_DROP;
        end
        S_ADDR: if (inBeat) state <= sLast ? S_FLEN : S_CLO;
        S_CLO: if (inBeat) begin
          cnt[7:0] <= sData;
          state <= sLast ? S_FLEN : S_CHI;
        end
        S_CHI: if (inBeat) begin
          cnt[15:8] <= sData; dCnt <= '0;
          state <= sLast ? R_LEN1 : S_BODY;
        end
        S_BODY: if (inBeat) begin
          if (bodyWr) dCnt <= dCnt + 16'd1;
          if (sLast) state <= R_LEN1;
        end
        S_DROP: if (inBeat && sLast) state <= S_FLEN;
        R_LEN1: if (outBeat) begin
          idx <= '0;
          state <= (rLen == 8'd0) ? R_LEN2 : R_RET;
        end
        R_RET: if (outBeat) begin
          if (idx == rLen - 8'd1) state <= R_LEN2;
          else idx <= idx + 8'd1;
        end
        R_LEN2: if (outBeat) begin
          idx <= '0;
          state <= (fLen == 8'd0) ? R_TYPE : R_FWD;
        end
        R_FWD: if (outBeat) begin
          if (idx == fLen - 8'd1) state <= R_TYPE;
          else idx <= idx + 8'd1;
        end
        R_TYPE: if (outBeat) begin
          idx <= '0;
          state <= (typ == TYP_IDENT) ? R_DESC : R_ADDR;
        end
        R_ADDR: if (outBeat) state <= R_CLO;
        R_CLO:  if (outBeat) state <= R_CHI;
        R_CHI: if (outBeat) begin
          dCnt <= '0;
          state <= mLast ? S_FLEN : R_DATA;
        end
        R_DATA: if (outBeat) begin
          if (mLast) state <= S_FLEN;
          else dCnt <= dCnt + 16'd1;
        end
        R_DESC: if (outBeat) begin
          if (mLast) state <= S_FLEN;
          else idx <= idx + 8'd1;
        end
        default: state <= S_FLEN;
      endcase
    end
  end

  // R4
  ram_write_on_input_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.ramWe |-> (sValid && sReady));

  // R11
  reply_then_listen_chk: assert property (@(posedge clk) disable iff (rst)
    (mValid && mReady && mLast) |=> (sReady && !mValid));
endmodule

// File: rtl/cpkt_dpath.sv
module cpkt_dpath
  import cpkt_pkg::*;
#(
  parameter int MAX_PATH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sData,
  input  strobe_t    strobe,
  input  logic [7:0] slotIdx,
  input  logic [7:0] constByte,
  output logic [7:0] mData
);
  localparam int SLOT_W = (MAX_PATH > 1) ? $clog2(MAX_PATH) : 1;

  logic [7:0] mem [RAM_BYTES];
  logic [7:0] fwdSlot [MAX_PATH];
  logic [7:0] retSlot [MAX_PATH];
  logic [ADDR_W-1:0] curAddr, reqAddr, nextAddr;
  logic [7:0] ramQ;
  logic [SLOT_W-1:0] slot;

  assign slot = slotIdx[SLOT_W-1:0];

  always_comb begin
    if (strobe.addrLd) nextAddr = sData[ADDR_W-1:0];
    else if (strobe.addrAdv) nextAddr = curAddr + 1'b1;
    else nextAddr = curAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
      reqAddr <= '0;
    end else begin
      curAddr <= nextAddr;
      if (strobe.addrLd) reqAddr <= sData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[curAddr] <= sData;
    ramQ <= mem[nextAddr];
  end

  for (genvar g = 0; g < MAX_PATH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        fwdSlot[g] <= '0;
        retSlot[g] <= '0;
      end else begin
        if (strobe.fwdWe && slot == SLOT_W'(g)) fwdSlot[g] <= sData;
        if (strobe.retWe && slot == SLOT_W'(g)) retSlot[g] <= sData;
      end
    end
  end

  always_comb begin
    case (strobe.outSel)
      OS_FWD:  mData = fwdSlot[slot];
      OS_RET:  mData = retSlot[slot];
      OS_ADDR: mData = 8'(reqAddr);
      OS_RAM:  mData = ramQ;
      default: mData = constByte;
    endcase
  end

  // R6
  addr_step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.addrAdv && !strobe.addrLd) |=> (curAddr == $past(curAddr) + 1'b1));
endmodule

// File: rtl/ctl_mem_endpoint.sv
module ctl_mem_endpoint
  import cpkt_pkg::*;
#(
  parameter int MAX_PATH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sData,
  input  logic       sValid,
  input  logic       sLast,
  output logic       sReady,
  output logic [7:0] mData,
  output logic       mValid,
  output logic       mLast,
  input  logic       mReady
);
  strobe_t    strobe;
  logic [7:0] constByte;
  logic [7:0] slotIdx;

  cpkt_ctl #(.MAX_PATH(MAX_PATH)) u_ctl (
    .clk(clk), .rst(rst), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sReady(sReady), .mReady(mReady), .mValid(mValid), .mLast(mLast),
    .constByte(constByte), .slotIdx(slotIdx), .strobe(strobe)
  );

  cpkt_dpath #(.MAX_PATH(MAX_PATH)) u_dpath (
    .clk(clk), .rst(rst), .sData(sData), .strobe(strobe), .slotIdx(slotIdx),
    .constByte(constByte), .mData(mData)
  );

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mValid && !mReady) |=> (mValid && $stable(mData) && $stable(mLast)));

  // R10
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    mLast |-> mValid);

  // R11
  no_input_in_reply_chk: assert property (@(posedge clk) disable iff (rst)
    mValid |-> !sReady);
endmodule

// File: tb/tb_ctl_mem_endpoint.sv
`timescale 1ns/1ps
module tb_ctl_mem_endpoint;
  localparam int MAXP = 4;
  logic clk = 0, rst = 1;
  logic [7:0] sData = 0;
  logic sValid = 0, sLast = 0, mReady = 1;
  logic sReady, mValid, mLast;
  logic [7:0] mData;

  ctl_mem_endpoint #(.MAX_PATH(MAXP)) dut (
    .clk(clk), .rst(rst), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sReady(sReady), .mData(mData), .mValid(mValid), .mLast(mLast), .mReady(mReady)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, beats = 0, cyc = 0;
  bit running = 0, stallMode = 0, finished = 0;
  string curTag = "R1";
  logic [7:0] expD[$];
  bit expL[$];
  logic [7:0] refMem[256];
  logic [7:0] pk[$];
  logic [15:0] lfsr = 16'hACE1;
  bit prevHeld = 0;
  logic [7:0] prevD;
  bit prevL;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic logic [7:0] descRef(int i);
    case (i)
      0: return 8'h01;
      1: return 8'h08;
      2: return 8'h00;
      3: return 8'h01;
      default: return 8'(8'h40 + i);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    if (running) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mReady = stallMode ? lfsr[0] : 1'b1;
      if (prevHeld)
        chk(mValid && mData === prevD && mLast === prevL, "R10", "hold under stall",
            int'(mData), int'(prevD));
      if (mValid) chk(!sReady, "R11", "sReady during reply", int'(sReady), 0);
      if (mValid && mReady) begin
        beats++;
        if (expD.size() == 0) begin
          chk(0, curTag, "unexpected reply byte", int'(mData), -1);
        end else begin
          logic [7:0] e;
          bit el;
          e = expD.pop_front();
          el = expL.pop_front();
          chk(mData === e, curTag, "reply byte", int'(mData), int'(e));
          chk(mLast === el, (curTag == "R12") ? "R12" : "R10", "last flag", int'(mLast), int'(el));
        end
      end
      prevHeld = mValid && !mReady;
      prevD = mData;
      prevL = mLast;
    end
  end

  task automatic model();
    int n, i, pl, rl, typ, addr, cnt;
    logic [7:0] r[$];
    n = pk.size();
    if (n < 1) return;
    pl = pk[0];
    if (pl > MAXP || 1 + pl >= n) return;
    rl = pk[1 + pl];
    if (rl > MAXP) return;
    i = 2 + pl + rl;
    if (i >= n) return;
    typ = pk[i];
    i++;
    r.push_back(8'(rl));
    for (int k = 0; k < rl; k++) r.push_back(pk[2 + pl + k]);
    r.push_back(8'(pl));
    for (int k = 0; k < pl; k++) r.push_back(pk[1 + k]);
    if (typ == 8'hFE) begin
      r.push_back(8'hFF);
      for (int k = 0; k < 32; k++) r.push_back(descRef(k));
    end else if (typ == 8'h10 || typ == 8'h12) begin
      if (i + 2 >= n) return;
      addr = pk[i];
      cnt = int'(pk[i + 1]) | (int'(pk[i + 2]) << 8);
      r.push_back(8'(typ + 1));
      r.push_back(8'(addr));
      r.push_back(pk[i + 1]);
      r.push_back(pk[i + 2]);
      if (typ == 8'h12)
        for (int k = 0; k < cnt && i + 3 + k < n; k++) refMem[(addr + k) % 256] = pk[i + 3 + k];
      else
        for (int k = 0; k < cnt; k++) r.push_back(refMem[(addr + k) % 256]);
    end else return;
    for (int k = 0; k < r.size(); k++) begin
      expD.push_back(r[k]);
      expL.push_back(k == r.size() - 1);
    end
  endtask

  task automatic sendPk();
    for (int k = 0; k < pk.size(); k++) begin
      @(negedge clk);
      sValid = 0;
      while (!sReady) @(negedge clk);
      sValid = 1;
      sData = pk[k];
      sLast = (k == pk.size() - 1);
    end
    @(negedge clk);
    sValid = 0;
    sLast = 0;
  endtask

  task automatic runPk(string tag);
    curTag = tag;
    model();
    sendPk();
    while (expD.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic dropPk(string tag, string what);
    int b0;
    b0 = beats;
    runPk(tag);
    repeat (20) @(negedge clk);
    chk(beats == b0, tag, what, beats - b0, 0);
    chk(sReady === 1'b1, tag, "ready after drop", int'(sReady), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(mValid === 1'b0, "R1", "mValid after reset", int'(mValid), 0);
    chk(sReady === 1'b1, "R1", "sReady after reset", int'(sReady), 1);
    running = 1;

    // R2 R5: identify with empty routing lists
    pk = {8'd0, 8'd0, 8'hFE};
    runPk("R2");
    // R5: nonempty lists swapped in reply
    pk = {8'd2, 8'h01, 8'h02, 8'd3, 8'h07, 8'h08, 8'h09, 8'hFE};
    runPk("R5");
    // R4 R5: write with forward path
    pk = {8'd1, 8'h03, 8'd0, 8'h12, 8'h10, 8'h04, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44};
    runPk("R4");
    // R3: read back
    pk = {8'd0, 8'd0, 8'h10, 8'h10, 8'h04, 8'h00};
    runPk("R3");
    // R6: write crossing the top of the RAM, read back with stalls
    pk = {8'd0, 8'd0, 8'h12, 8'hFD, 8'h05, 8'h00, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
    runPk("R6");
    stallMode = 1;
    pk = {8'd0, 8'd1, 8'h05, 8'h10, 8'hFD, 8'h05, 8'h00};
    runPk("R6");
    // R4: bytes past the count are ignored
    pk = {8'd0, 8'd0, 8'h12, 8'h40, 8'h03, 8'h00, 8'h05, 8'h06, 8'h07};
    runPk("R4");
    pk = {8'd0, 8'd0, 8'h12, 8'h40, 8'h02, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44};
    runPk("R4");
    pk = {8'd0, 8'd0, 8'h10, 8'h40, 8'h03, 8'h00};
    runPk("R4");
    // R10: identify with path lists under stall
    pk = {8'd4, 8'h01, 8'h02, 8'h03, 8'h04, 8'd4, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'hFE};
    runPk("R10");
    stallMode = 0;
    // R12: zero-length read
    pk = {8'd0, 8'd0, 8'h10, 8'h22, 8'h00, 8'h00};
    runPk("R12");
    // R7: unknown type
    pk = {8'd0, 8'd0, 8'h33, 8'h01, 8'h02, 8'h03};
    dropPk("R7", "reply to unknown type");
    // R8: truncated packets
    pk = {8'd1};
    dropPk("R8", "reply after path length only");
    pk = {8'd1, 8'h05, 8'd0};
    dropPk("R8", "reply without type");
    pk = {8'd0, 8'd0, 8'h10, 8'h20, 8'h02};
    dropPk("R8", "reply to read missing count high");
    pk = {8'd0, 8'd0, 8'h12};
    dropPk("R8", "reply to write ending at type");
    // R9: overlong path
    pk = {8'd5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'd0, 8'hFE};
    dropPk("R9", "reply to overlong path");
    pk = {8'd0, 8'd5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'hFE};
    dropPk("R9", "reply to overlong return path");
    // R7: still alive after drops
    pk = {8'd0, 8'd0, 8'h10, 8'h10, 8'h02, 8'h00};
    runPk("R7");

    chk(expD.size() == 0, "R3", "outstanding reply bytes", expD.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule